// File: doc/BRIEF.md
# Dual Reference Clock Stall Monitor

This block watches two reference clock inputs and reports, for each one, whether it has stopped toggling. A third clock, the feedback clock, sets the measurement window. An input that shows no edge during one whole feedback period is marked bad. All logic runs on a separate, faster system clock. Each monitored clock and the feedback clock pass through two-flop synchronizers before any edge detection. The monitored clocks must run slower than half the system clock.

The flags show live health. A bad flag drops again at the first feedback period in which its input toggles. A falling edge on the active-low initialization input forces both flags low. Evaluation then restarts from a fresh feedback period, so no flag can rise again before a full clean window has passed. A synchronous active-high reset has the same effect and also clears all edge history.

Top module: `clk_loss_monitor`

## Requirements
- R1: An input held high through a full feedback period drives its bad flag (bad_o bit 0 for ref_clk_i bit 0, bit 1 for bit 1) to 1 no later than the second rising feedback edge after it stops.
- R2: An input held low through a full feedback period drives its bad flag to 1 in the same way.
- R3: Each flag depends only on its own input: a failing input never raises the other input's flag.
- R4: A bad flag changes only when a rising feedback edge is evaluated or when the flags are cleared. It returns to 0 at the first evaluation whose window contained an edge on that input.
- R5: A high-to-low transition on init_n_i clears both flags within 6 system clock cycles. A low-to-high transition on init_n_i does not change them.
- R6: After an init falling edge, the next rising feedback edge only opens a new window. No flag can be set before the second rising feedback edge.
- R7: While rst_i is high at a system clock edge, both flags and all edge history are cleared. The first rising feedback edge after reset only opens a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock for all logic |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_clk_i | input | NUM_IN (2) | Monitored reference clocks, asynchronous |
| fb_clk_i | input | 1 | Feedback clock that sets the measurement window, asynchronous |
| init_n_i | input | 1 | Initialization input, acts on its falling edge |
| bad_o | output | NUM_IN (2) | Per-input stall flag, 1 = no edge in the last window |

## Verification
The hardest case to reach is the fresh-window rule after an init edge. The input must already be stalled with its flag set when init falls, and the init fall must come clear of a feedback edge. Only then does the observation after the next feedback edge separate an armed window from an unarmed one. The bench lines up the init pulse a few system cycles after a feedback rising edge and samples after each of the next two feedback edges. It applies the same staging to a reset issued in mid-run. The stall cases are swept over both inputs and both stuck levels, and the other input's flag is checked in every case.

// File: rtl/clm_pkg.sv
package clm_pkg;

    // state of the feedback window sequencer
    typedef struct packed {
        logic fb_prev;
        logic init_prev;
        logic armed;
    } win_st_t;

    // state of one per-input stall watcher
    typedef struct packed {
        logic prev;
        logic seen;
        logic bad;
    } watch_st_t;

endpackage

// File: rtl/clm_sync.sv
module clm_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= {STAGES{{WIDTH{RST_VAL}}}};
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/clm_window.sv
module clm_window
    import clm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic fb_s_i,
    input  logic init_n_s_i,
    output logic check_o,
    output logic start_o,
    output logic flag_clr_o
);
    win_st_t st_d, st_q;
    logic fb_rise, init_fall;

    always_comb begin
        st_d      = st_q;
        fb_rise   = fb_s_i & ~st_q.fb_prev;
        init_fall = ~init_n_s_i & st_q.init_prev;

        check_o    = fb_rise & st_q.armed & ~init_fall;
        start_o    = init_fall | (fb_rise & ~st_q.armed);
        flag_clr_o = init_fall;

        st_d.fb_prev   = fb_s_i;
        st_d.init_prev = init_n_s_i;
        if (init_fall) begin
            st_d.armed = 1'b0;
        end else if (fb_rise) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{fb_prev: 1'b1, init_prev: 1'b1, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_CHECK_ONLY_ARMED: assert property (@(posedge clk_i) disable iff (rst_i)
        check_o |-> st_q.armed);  // R6
    AST_INIT_DISARMS: assert property (@(posedge clk_i) disable iff (rst_i)
        flag_clr_o |=> !st_q.armed);  // R6
    AST_START_CHECK_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({check_o, start_o}));  // R4
endmodule

// File: rtl/clm_watch.sv
module clm_watch
    import clm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic mon_s_i,
    input  logic check_i,
    input  logic start_i,
    input  logic flag_clr_i,
    output logic bad_o
);
    watch_st_t st_d, st_q;
    logic edge_now;

    always_comb begin
        st_d     = st_q;
        edge_now = mon_s_i ^ st_q.prev;

        st_d.prev = mon_s_i;
        if (check_i || start_i) begin
            st_d.seen = 1'b0;
        end else begin
            st_d.seen = st_q.seen | edge_now;
        end

        if (flag_clr_i) begin
            st_d.bad = 1'b0;
        end else if (check_i) begin
            st_d.bad = ~(st_q.seen | edge_now);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bad_o = st_q.bad;

    AST_RISE_AT_CHECK: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(st_q.bad) |-> $past(check_i));  // R1
    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        flag_clr_i |=> !st_q.bad);  // R5
    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!check_i && !flag_clr_i) |=> $stable(st_q.bad));  // R4
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
    parameter int NUM_IN      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_IN-1:0] ref_clk_i,
    input  logic              fb_clk_i,
    input  logic              init_n_i,
    output logic [NUM_IN-1:0] bad_o
);
    localparam int CtlW = 2;

    logic [NUM_IN-1:0] ref_s;
    logic [CtlW-1:0]   ctl_s;
    logic              check, start, flag_clr;

    clm_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (ref_clk_i),
        .sync_o  (ref_s)
    );

    clm_sync #(.WIDTH(CtlW), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ctl_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i ({fb_clk_i, init_n_i}),
        .sync_o  (ctl_s)
    );

    clm_window u_window (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .fb_s_i     (ctl_s[1]),
        .init_n_s_i (ctl_s[0]),
        .check_o    (check),
        .start_o    (start),
        .flag_clr_o (flag_clr)
    );

    for (genvar i = 0; i < NUM_IN; i++) begin : g_watch
        clm_watch u_watch (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .mon_s_i    (ref_s[i]),
            .check_i    (check),
            .start_i    (start),
            .flag_clr_i (flag_clr),
            .bad_o      (bad_o[i])
        );
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (bad_o == '0));  // R7
endmodule

// File: tb/clk_loss_monitor_tb.sv
module clk_loss_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FB_HALF    = 200;
    localparam int REF_HALF   = 30;
    localparam int SETTLE     = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ref_clk = 2'b00;
    logic       fb_clk = 1'b0;
    logic       init_n = 1'b1;
    logic [1:0] bad;
    logic [1:0] run = 2'b11;
    logic [1:0] lvl = 2'b00;

    int checks = 0;
    int errors = 0;

    clk_loss_monitor u_dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .ref_clk_i (ref_clk),
        .fb_clk_i  (fb_clk),
        .init_n_i  (init_n),
        .bad_o     (bad)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(FB_HALF) fb_clk = ~fb_clk;
    always #(REF_HALF) ref_clk[0] = run[0] ? ~ref_clk[0] : lvl[0];
    always #(REF_HALF + 7) ref_clk[1] = run[1] ? ~ref_clk[1] : lvl[1];

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic after_fb(input int n);
        for (int k = 0; k < n; k++) @(posedge fb_clk);
        repeat (SETTLE) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 reset bad0", bad[0], 1'b0);
        chk("R7 reset bad1", bad[1], 1'b0);
        after_fb(2);
        chk("R4 healty bad0", bad[0], 1'b0);
        chk("R4 healthy bad1", bad[1], 1'b0);

        // sweep: each input, each stuck level
        for (int i = 0; i < 2; i++) begin
            for (int l = 0; l < 2; l++) begin
                lvl[i] = l[0];
                run[i] = 1'b0;
                after_fb(3);
                chk(l ? "R1 stuck high flag" : "R2 stuck low flag", bad[i], 1'b1);
                chk("R3 other flag untouched", bad[1-i], 1'b0);
                run[i] = 1'b1;
                after_fb(2);
                chk("R4 flag clears on recovery", bad[i], 1'b0);
                chk("R3 other flag after recovery", bad[1-i], 1'b0);
            end
        end

        // init behaviour with input 0 stuck high
        lvl[0] = 1'b1;
        run[0] = 1'b0;
        after_fb(3);
        chk("R1 flag before init", bad[0], 1'b1);
        init_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 init fall clears bad0", bad[0], 1'b0);
        chk("R5 init fall clears bad1", bad[1], 1'b0);
        after_fb(1);
        chk("R6 first fb after init only opens window", bad[0], 1'b0);
        after_fb(1);
        chk("R6 second fb after init evaluates", bad[0], 1'b1);
        init_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 init rise has no effect", bad[0], 1'b1);
        run[0] = 1'b1;
        after_fb(2);
        chk("R4 recovery after init test", bad[0], 1'b0);

        // mid-run reset with input 1 stuck low
        lvl[1] = 1'b0;
        run[1] = 1'b0;
        after_fb(3);
        chk("R2 flag before reset", bad[1], 1'b1);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 reset clears bad1", bad[1], 1'b0);
        after_fb(1);
        chk("R7 first fb after reset opens window", bad[1], 1'b0);
        after_fb(1);
        chk("R7 second fb after reset evaluates", bad[1], 1'b1);
        chk("R3 healthy input during reset test", bad[0], 1'b0);
        run[1] = 1'b1;
        after_fb(2);
        chk("R4 final recovery", bad[1], 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule